// File: doc/BRIEF.md
# Delay-Line Slot Scheduler

This block is the electronic controller of a slotted switch whose packets wait in fibre delay lines before they reach an output crossbar. All packets are the same length and occupy exactly one slot, so arrivals and departures fall on slot boundaries. Each clock cycle is one slot. In each slot, every input with a packet presents a destination port. The scheduler gives the packet a delay line, whose index is also its delay in slots. When no line is legal, it parks the packet on a one-slot recirculation line, or drops it.

The choice is made so that the output stage never sees a conflict. One delay line takes at most one packet per slot. Two packets for the same destination never leave in the same slot. To enforce the second rule, the block keeps a circular record of future exit slots. Each entry holds a one-hot destination word per delay line. The head entry, which describes the packets leaving now, drives the crossbar setting directly. Packets returning from recirculation compete again in the next slot, ahead of new arrivals. Running totals of accepted packets, dropped packets and granted delay are kept for performance monitoring.

Requesters are numbered in one list. Indices 0 to R-1 are the recirculation lines, in line order. Indices R to R+N-1 are the inputs, in port order.

Top module: `dl_slot_sched`

## Requirements
- R1: After reset the crossbar setting is all zero, no recirculation line is active, and all three counters read zero.
- R2: Requesters are served in ascending index order. Each requester takes the smallest delay d (1..S) whose line is still unused in this slot and whose exit slot (now + d) holds no packet for the same destination. reqDelay carries d in 3-bit field p of requester p, with 0 meaning no direct grant.
- R3: No delay line is granted to more than one requester in the same slot.
- R4: In any slot, each destination column of the crossbar setting has at most one bit set.
- R5: A packet granted delay d to destination k in slot t sets bit (d-1)*N+k of xbar in slot t+d. Row d-1 of xbar belongs to delay line d, and column k belongs to destination k.
- R6: A requester with no legal direct line takes the lowest recirculation line not yet taken in this slot. This is shown by reqRecirc bit p, with the line number in reqRcLine field p. That line's rcActive bit is set in the next slot, when the packet returns as requester number equal to its line.
- R7: Packets returning on recirculation lines choose their delay line before any new arrival in the same slot.
- R8: Every valid requester gets exactly one outcome: a direct delay, a recirculation line, or a drop (reqDrop bit p). A requester without a packet gets none. A drop happens only when neither a legal line nor a free recirculation line remains.
- R9: acceptCount grows by the number of direct grants per slot, dropCount by the number of drops, and delaySum by the sum of granted delays.
- R10: With the recirculation option disabled (RC_EN = 0), a packet with no legal direct line is dropped and reqRecirc stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one cycle per slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | N | A packet is present at input port i |
| inDest | input | N*DW | Destination of port i in field i |
| reqDelay | output | P*LW | Granted delay per requester, 0 for none |
| reqRecirc | output | P | Requester is placed on a recirculation line |
| reqRcLine | output | P*RW | Recirculation line chosen per requester |
| reqDrop | output | P | Requester's packet is discarded |
| rcActive | output | R | Recirculation line returns a packet this slot |
| xbar | output | S*N | Crossbar setting for this slot, row per line, one-hot destination |
| acceptCount | output | CW | Total direct grants |
| dropCount | output | CW | Total drops |
| delaySum | output | CW | Total of granted delays |

## Verification
The checker watches several properties on every cycle: single use of each line, a unique destination per crossbar column, exactly one outcome per requester, return of parked packets one slot later, the appearance of delay-1 grants on the next crossbar setting, and counter accumulation. The bench has to show the properties that depend on a particular order. These are the smallest-delay choice, the precedence of returning packets over arrivals, the fact that a grant reappears d slots later on longer lines, and the drop-only variant. Its vector table follows a sequence in which future exits pile up on one destination until both recirculation lines overflow.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int STB_W = 16;

  // Per-slot strobes sent from the allocation logic to the state holder.
  typedef struct packed {
    logic [STB_W-1:0] nAccept;
    logic [STB_W-1:0] nDrop;
    logic [STB_W-1:0] delayAdd;
  } slotStb_t;
endpackage

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
#(
  parameter int N = 4,
  parameter int S = 4,
  parameter int R = 2,
  parameter int RC_EN = 1,
  parameter int DW = 2,
  parameter int LW = 3,
  parameter int RW = 1,
  parameter int P = 6
) (
  input  logic [P-1:0]                reqValid,
  input  logic [P-1:0][DW-1:0]        reqDest,
  input  logic [S-1:0][N-1:0]         futMask,
  output logic [P-1:0][LW-1:0]        reqDelay,
  output logic [P-1:0]                reqRecirc,
  output logic [P-1:0][RW-1:0]        reqRcLine,
  output logic [P-1:0]                reqDrop,
  output logic [S-1:0][N-1:0]         lineWr,
  output logic [R-1:0]                rcLoad,
  output logic [R-1:0][DW-1:0]        rcLoadDest,
  output slotStb_t                    stb
);
  localparam int RC_CAP = (RC_EN != 0) ? R : 0;

  logic [S-1:0] lineUsed;
  logic         found;
  int           rcCnt;

  // Sequential greedy allocation in requester order, smallest delay first.
  always_comb begin
    lineUsed   = '0;
    lineWr     = '0;
    reqDelay   = '0;
    reqRecirc  = '0;
    reqRcLine  = '0;
    reqDrop    = '0;
    rcLoad     = '0;
    rcLoadDest = '0;
    stb        = '0;
    rcCnt      = 0;
    found      = 1'b0;
    for (int p = 0; p < P; p++) begin
      found = 1'b0;
      if (reqValid[p]) begin
        for (int d = 1; d <= S; d++) begin
          if (!found && !lineUsed[d-1] && !futMask[d-1][reqDest[p]]) begin
            found                   = 1'b1;
            lineUsed[d-1]           = 1'b1;
            lineWr[d-1][reqDest[p]] = 1'b1;
            reqDelay[p]             = LW'(d);
            stb.nAccept             = stb.nAccept + 1'b1;
            stb.delayAdd            = stb.delayAdd + STB_W'(d);
          end
        end
        if (!found) begin
          if (rcCnt < RC_CAP) begin
            reqRecirc[p]      = 1'b1;
            reqRcLine[p]      = RW'(rcCnt);
            rcLoad[rcCnt]     = 1'b1;
            rcLoadDest[rcCnt] = reqDest[p];
            rcCnt             = rcCnt + 1;
          end else begin
            reqDrop[p] = 1'b1;
            stb.nDrop  = stb.nDrop + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dls_dp.sv
module dls_dp
  import dls_pkg::*;
#(
  parameter int N = 4,
  parameter int S = 4,
  parameter int R = 2,
  parameter int RC_EN = 1,
  parameter int DW = 2,
  parameter int CW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [S-1:0][N-1:0]   lineWr,
  input  logic [R-1:0]          rcLoad,
  input  logic [R-1:0][DW-1:0]  rcLoadDest,
  input  slotStb_t              stb,
  output logic [S-1:0][N-1:0]   futMask,
  output logic [S-1:0][N-1:0]   xbarNow,
  output logic [R-1:0]          rcValid,
  output logic [R-1:0][DW-1:0]  rcDest,
  output logic [CW-1:0]         acceptCount,
  output logic [CW-1:0]         dropCount,
  output logic [CW-1:0]         delaySum
);
  localparam int HW = (S > 1) ? $clog2(S) : 1;

  // ring[exit entry][delay line] = one-hot destination leaving on that line
  logic [S-1:0][S-1:0][N-1:0] ring;
  logic [HW-1:0]              head;

  function automatic logic [HW-1:0] slotIdx(input logic [HW-1:0] h, input int d);
    return HW'((int'(h) + d) % S);
  endfunction

  // Destinations already due in each future slot; the slot S ahead reuses
  // the head entry, which is cleared at this edge, so it starts empty.
  always_comb begin
    futMask = '0;
    for (int d = 1; d < S; d++) begin
      for (int l = 0; l < S; l++) begin
        futMask[d-1] = futMask[d-1] | ring[slotIdx(head, d)][l];
      end
    end
  end

  assign xbarNow = ring[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= '0;
      head <= '0;
    end else begin
      for (int d = 1; d < S; d++) begin
        ring[slotIdx(head, d)][d-1] <= ring[slotIdx(head, d)][d-1] | lineWr[d-1];
      end
      ring[head]      <= '0;
      ring[head][S-1] <= lineWr[S-1];
      head            <= (head == HW'(S - 1)) ? '0 : head + 1'b1;
    end
  end

  generate
    if (RC_EN != 0) begin : g_rc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rcValid <= '0;
          rcDest  <= '0;
        end else begin
          rcValid <= rcLoad;
          rcDest  <= rcLoadDest;
        end
      end
    end else begin : g_norc
      assign rcValid = '0;
      assign rcDest  = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acceptCount <= '0;
      dropCount   <= '0;
      delaySum    <= '0;
    end else begin
      acceptCount <= acceptCount + CW'(stb.nAccept);
      dropCount   <= dropCount + CW'(stb.nDrop);
      delaySum    <= delaySum + CW'(stb.delayAdd);
    end
  end
endmodule

// File: rtl/dl_slot_sched.sv
module dl_slot_sched
  import dls_pkg::*;
#(
  parameter int N = 4,
  parameter int S = 4,
  parameter int R = 2,
  parameter int RC_EN = 1,
  parameter int CW = 16,
  localparam int DW = (N > 1) ? $clog2(N) : 1,
  localparam int LW = $clog2(S + 1),
  localparam int RW = (R > 1) ? $clog2(R) : 1,
  localparam int P = R + N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    inValid,
  input  logic [N*DW-1:0] inDest,
  output logic [P*LW-1:0] reqDelay,
  output logic [P-1:0]    reqRecirc,
  output logic [P*RW-1:0] reqRcLine,
  output logic [P-1:0]    reqDrop,
  output logic [R-1:0]    rcActive,
  output logic [S*N-1:0]  xbar,
  output logic [CW-1:0]   acceptCount,
  output logic [CW-1:0]   dropCount,
  output logic [CW-1:0]   delaySum
);
  logic [P-1:0]          reqValid;
  logic [P-1:0][DW-1:0]  reqDest;
  logic [S-1:0][N-1:0]   futMask;
  logic [S-1:0][N-1:0]   lineWr;
  logic [S-1:0][N-1:0]   xbarNow;
  logic [R-1:0]          rcLoad;
  logic [R-1:0][DW-1:0]  rcLoadDest;
  logic [R-1:0]          rcValid;
  logic [R-1:0][DW-1:0]  rcDest;
  logic [P-1:0][LW-1:0]  delayA;
  logic [P-1:0][RW-1:0]  rcLineA;
  slotStb_t              stb;

  // Returning packets first, then inputs in port order.
  assign reqValid = {inValid, rcValid};
  genvar g;
  generate
    for (g = 0; g < R; g++) begin : g_rq
      assign reqDest[g] = rcDest[g];
    end
    for (g = 0; g < N; g++) begin : g_iq
      assign reqDest[R+g] = inDest[g*DW +: DW];
    end
  endgenerate

  dls_ctrl #(.N(N), .S(S), .R(R), .RC_EN(RC_EN), .DW(DW), .LW(LW), .RW(RW), .P(P)) u_ctrl (
    .reqValid(reqValid), .reqDest(reqDest), .futMask(futMask),
    .reqDelay(delayA), .reqRecirc(reqRecirc), .reqRcLine(rcLineA), .reqDrop(reqDrop),
    .lineWr(lineWr), .rcLoad(rcLoad), .rcLoadDest(rcLoadDest), .stb(stb)
  );

  dls_dp #(.N(N), .S(S), .R(R), .RC_EN(RC_EN), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .lineWr(lineWr), .rcLoad(rcLoad), .rcLoadDest(rcLoadDest),
    .stb(stb), .futMask(futMask), .xbarNow(xbarNow), .rcValid(rcValid), .rcDest(rcDest),
    .acceptCount(acceptCount), .dropCount(dropCount), .delaySum(delaySum)
  );

  assign reqDelay  = delayA;
  assign reqRcLine = rcLineA;
  assign rcActive  = rcValid;
  assign xbar      = xbarNow;
endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int N = 4,
  parameter int S = 4,
  parameter int R = 2,
  parameter int CW = 16,
  parameter int DW = 2,
  parameter int LW = 3,
  parameter int RW = 1,
  parameter int P = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    inValid,
  input logic [N*DW-1:0] inDest,
  input logic [P*LW-1:0] reqDelay,
  input logic [P-1:0]    reqRecirc,
  input logic [P*RW-1:0] reqRcLine,
  input logic [P-1:0]    reqDrop,
  input logic [R-1:0]    rcActive,
  input logic [S*N-1:0]  xbar,
  input logic [CW-1:0]   acceptCount
);
  logic [P-1:0]    reqV;
  logic            lineOnce;
  logic [R-1:0]    rcLoaded;
  logic [N-1:0]    d1Mask;
  logic [CW-1:0]   nDirect;
  logic [N-1:0][S-1:0] colVec;
  logic [P-1:0][DW-1:0] dstA;

  assign reqV = {inValid, rcActive};

  always_comb begin
    lineOnce = 1'b1;
    rcLoaded = '0;
    d1Mask   = '0;
    nDirect  = '0;
    dstA     = '0;
    for (int p = R; p < P; p++) dstA[p] = inDest[(p-R)*DW +: DW];
    for (int l = 1; l <= S; l++) begin
      int hits;
      hits = 0;
      for (int p = 0; p < P; p++) if (int'(reqDelay[p*LW +: LW]) == l) hits++;
      if (hits > 1) lineOnce = 1'b0;
    end
    for (int p = 0; p < P; p++) begin
      if (reqDelay[p*LW +: LW] != '0) nDirect = nDirect + 1'b1;
      if (reqRecirc[p]) rcLoaded[reqRcLine[p*RW +: RW]] = 1'b1;
      if (p >= R && reqDelay[p*LW +: LW] == LW'(1)) d1Mask[dstA[p]] = 1'b1;
    end
  end

  genvar k, l;
  generate
    for (k = 0; k < N; k++) begin : g_col
      for (l = 0; l < S; l++) begin : g_row
        assign colVec[k][l] = xbar[l*N+k];
      end
      p_dest_unique_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(colVec[k]));
    end
    for (k = 0; k < P; k++) begin : g_out
      p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reqV[k] |-> $onehot({reqDelay[k*LW +: LW] != '0, reqRecirc[k], reqDrop[k]}));
      p_no_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reqV[k] |-> ({reqDelay[k*LW +: LW] != '0, reqRecirc[k], reqDrop[k]} == 3'b000));
    end
  endgenerate

  p_line_once_r3: assert property (@(posedge clk) disable iff (!rst_n) lineOnce);

  // Only input grants are tracked here; returning packets carry no port destination.
  p_arrival_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rcActive == '0) |=> ((xbar[N-1:0] & $past(d1Mask)) == $past(d1Mask)));

  p_recirc_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rcActive == $past(rcLoaded)));

  p_accept_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (acceptCount == $past(acceptCount) + $past(nDirect)));
endmodule

bind dl_slot_sched dls_chk #(.N(N), .S(S), .R(R), .CW(CW), .DW(DW), .LW(LW), .RW(RW), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest), .reqDelay(reqDelay),
  .reqRecirc(reqRecirc), .reqRcLine(reqRcLine), .reqDrop(reqDrop), .rcActive(rcActive),
  .xbar(xbar), .acceptCount(acceptCount)
);

// File: tb/sim_dl_slot_sched.sv
module sim_dl_slot_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  inValid = '0, inValid1 = '0;
  logic [7:0]  inDest = '0, inDest1 = '0;
  logic [17:0] reqDelay, reqDelay1;
  logic [5:0]  reqRecirc, reqRcLine, reqDrop, reqRecirc1, reqRcLine1, reqDrop1;
  logic [1:0]  rcActive, rcActive1;
  logic [15:0] xbar, xbar1, accCnt, dropCnt, dSum, accCnt1, dropCnt1, dSum1;

  dl_slot_sched u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest), .reqDelay(reqDelay),
    .reqRecirc(reqRecirc), .reqRcLine(reqRcLine), .reqDrop(reqDrop), .rcActive(rcActive),
    .xbar(xbar), .acceptCount(accCnt), .dropCount(dropCnt), .delaySum(dSum));

  dl_slot_sched #(.RC_EN(0)) u1 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid1), .inDest(inDest1), .reqDelay(reqDelay1),
    .reqRecirc(reqRecirc1), .reqRcLine(reqRcLine1), .reqDrop(reqDrop1), .rcActive(rcActive1),
    .xbar(xbar1), .acceptCount(accCnt1), .dropCount(dropCnt1), .delaySum(dSum1));

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pk(input int a, b, c, d, e, f);
    return {3'(f), 3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  typedef struct packed {
    logic [3:0]  vld;
    logic [7:0]  dst;
    logic [17:0] dly;
    logic [5:0]  rc;
    logic [5:0]  line;
    logic [5:0]  drp;
    logic [1:0]  act;
    logic [15:0] xb;
  } vec_t;

  // Requesters 0..1 are recirculation lines, 2..5 are input ports 0..3.
  localparam vec_t VECS [6] = '{
    '{4'hF, 8'h00, pk(0,0,1,2,3,4), 6'b000000, 6'b000000, 6'b000000, 2'b00, 16'h0000},
    '{4'hF, 8'h00, pk(0,0,4,0,0,0), 6'b011000, 6'b010000, 6'b100000, 2'b00, 16'h0001},
    '{4'h7, 8'h25, pk(4,0,1,2,3,0), 6'b000010, 6'b000000, 6'b000000, 2'b11, 16'h0010},
    '{4'hB, 8'hCC, pk(4,0,0,1,0,2), 6'b000100, 6'b000000, 6'b000000, 2'b01, 16'h0102},
    '{4'h0, 8'h00, pk(4,0,0,0,0,0), 6'b000000, 6'b000000, 6'b000000, 2'b01, 16'h1028},
    '{4'hF, 8'hAA, pk(0,0,1,2,3,4), 6'b000000, 6'b000000, 6'b000000, 2'b00, 16'h1480}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 xbar reset", 64'(xbar), 64'h0);
    chk("R1 recirc reset", 64'(rcActive), 64'h0);
    chk("R1 counters reset", {accCnt, dropCnt, dSum}, 64'h0);

    for (int i = 0; i < 6; i++) begin
      inValid = VECS[i].vld;
      inDest  = VECS[i].dst;
      #2;
      chk($sformatf("R2/R7 delays slot %0d", i), 64'(reqDelay), 64'(VECS[i].dly));
      chk($sformatf("R6 recirc slot %0d", i), 64'(reqRecirc), 64'(VECS[i].rc));
      chk($sformatf("R6 recirc line slot %0d", i), 64'(reqRcLine & reqRecirc), 64'(VECS[i].line));
      chk($sformatf("R8 drop slot %0d", i), 64'(reqDrop), 64'(VECS[i].drp));
      chk($sformatf("R6 returning slot %0d", i), 64'(rcActive), 64'(VECS[i].act));
      chk($sformatf("R5/R4 xbar slot %0d", i), 64'(xbar), 64'(VECS[i].xb));
      @(negedge clk);
    end
    inValid = '0;
    inDest  = '0;
    #2;
    chk("R9 accepted", 64'(accCnt), 64'd17);
    chk("R9 dropped", 64'(dropCnt), 64'd1);
    chk("R9 delay sum", 64'(dSum), 64'd45);

    // R10: variant without recirculation drops instead of parking.
    @(negedge clk);
    inValid1 = 4'hF;
    inDest1  = 8'h00;
    #2;
    chk("R10 first slot delays", 64'(reqDelay1), 64'(pk(0,0,1,2,3,4)));
    @(negedge clk);
    #2;
    chk("R10 second slot delays", 64'(reqDelay1), 64'(pk(0,0,4,0,0,0)));
    chk("R10 drops", 64'(reqDrop1), 64'(6'b111000));
    chk("R10 no recirc", 64'(reqRecirc1), 64'h0);
    @(negedge clk);
    inValid1 = '0;
    #2;
    chk("R10 dropped count", 64'(dropCnt1), 64'd3);

    // R1: reset mid-run clears all state.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 xbar after rerun reset", 64'(xbar), 64'h0);
    chk("R1 counters after rerun reset", {accCnt, dropCnt, dSum}, 64'h0);
    chk("R1 returning after rerun reset", 64'(rcActive), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule